// File: doc/BRIEF.md
# GPIO Pin Interrupt Status and Enable Bank

This block holds the interrupt state for a bank of general-purpose pins, one identical slice per pin. Each slice watches the pin level after glitch filtering and after the optional polarity inversion. When detection is switched on for that pin, the slice records an event in a sticky status bit. In edge mode the event is a rising transition. In level mode it is a high level. Falling-edge or active-low sensing comes from inverting the pin ahead of this block. The detector itself always looks for a rising edge or a high level.

Software changes the status and the mask-enable of a pin only through strobe bits in a per-pin write. There are four strobes: one clears the status, one forces the status, one clears the enable and one sets the enable. A single write may combine strobes. Clearing the status and the enable together gives a mask-and-acknowledge in one access. Each pin's request output is its status gated by its enable. The bus decoder in front of the block turns the pin's register address into a pin index and passes on the low four data bits.

Top module: `gpio_irq_bank`

## Requirements
- R1: With detection on and edge mode selected (`edge_mode_i`=1), a 0-to-1 change of the sampled pin level sets that pin's status at the clock edge where the level is first seen high. The status then stays set after the level falls.
- R2: With detection on and level mode selected (`edge_mode_i`=0), the status is set at every clock edge at which the sampled level is high. A status-clear write therefore has no lasting effect while the level stays high.
- R3: With detection off (`det_en_i`=0), the pin level never changes the status.
- R4: A write with `wr_cmd_i` bit 1 set forces the status of the addressed pin to 1, whether detection is on or off.
- R5: A write with `wr_cmd_i` bit 0 set clears the status of the addressed pin. If a detection event or bit 1 applies to the same pin in the same cycle, the status ends up 1.
- R6: `wr_cmd_i` bit 3 sets the pin's enable and bit 2 clears it. When both bits are in one write, the enable ends up 0.
- R7: A write carrying bits 0 and 2 together clears both the status and the enable of the addressed pin.
- R8: `irq_o[p]` is high exactly when pin p has both its status and its enable set.
- R9: A write changes only the pin selected by `wr_pin_i`. All other pins keep their status and enable.
- R10: Reset clears every status, every enable and the stored edge history.
- R11: The edge history follows the pin even while detection is off. Turning detection on while the level is already high therefore produces no edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl_i | input | NUM_PINS | Filtered, polarity-adjusted pin levels |
| det_en_i | input | NUM_PINS | Per-pin detection enable from pin configuration |
| edge_mode_i | input | NUM_PINS | Per-pin sense type: 1 edge, 0 level |
| wr_en_i | input | 1 | Interrupt-register write strobe |
| wr_pin_i | input | PIN_W | Pin index addressed by the write |
| wr_cmd_i | input | 4 | Write data bits: 0 status clear, 1 status set, 2 enable clear, 3 enable set |
| status_o | output | NUM_PINS | Pending status per pin |
| enable_o | output | NUM_PINS | Mask-enable per pin |
| irq_o | output | NUM_PINS | Interrupt request per pin |

## Verification
A status bit stuck high or low shows up on `status_o` one clock after the input that should have moved it. It also shows on `irq_o` in the same cycle once that pin is enabled. A lost or stale edge history appears as a missing or extra status set in the clock after the pin rises, or after detection is switched on while the pin is high. A decode slip that hits the wrong pin corrupts a neighbour's bits on the clock after the write. The random phase writes to every pin index and compares all pins every cycle, so such a slip is caught at once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Write command strobes. The packed order matches wr_cmd_i bit positions:
    // bit 0 status clear, bit 1 status set, bit 2 enable clear, bit 3 enable set.
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic st_set;
        logic st_clr;
    } irq_cmd_t;

    localparam int CMD_W = $bits(irq_cmd_t);

    typedef struct packed {
        logic status;
        logic enable;
    } irq_state_t;

    typedef struct packed {
        logic prev_lvl;
    } det_state_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int PIN_W    = 3
) (
    input  logic                           wr_en_i,
    input  logic [PIN_W-1:0]               wr_pin_i,
    input  logic [CMD_W-1:0]               wr_cmd_i,
    output irq_cmd_t [NUM_PINS-1:0]        cmd_o
);

    // Route the strobes of one write to the addressed pin only.
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            cmd_o[p] = '0;
            if (wr_en_i && (wr_pin_i == PIN_W'(p))) begin
                cmd_o[p] = irq_cmd_t'(wr_cmd_i);
            end
        end
    end

endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic det_en_i,
    input  logic edge_mode_i,
    output logic evt_o
);

    det_state_t det_d, det_q;

    // History tracks the pin every cycle, even with detection off.
    always_comb begin
        det_d          = det_q;
        det_d.prev_lvl = lvl_i;
        if (!det_en_i) begin
            evt_o = 1'b0;
        end else if (edge_mode_i) begin
            evt_o = lvl_i & ~det_q.prev_lvl;
        end else begin
            evt_o = lvl_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    // R3: no event while detection is off
    a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en_i |-> !evt_o);

endmodule

// File: rtl/irq_pin_state.sv
module irq_pin_state
    import gpio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     evt_i,
    input  irq_cmd_t cmd_i,
    output logic     status_o,
    output logic     enable_o,
    output logic     irq_o
);

    irq_state_t st_d, st_q;

    // Status: clear first, then set or detection overrides it.
    // Enable: set first, then clear overrides it.
    always_comb begin
        st_d = st_q;
        if (cmd_i.st_clr) begin
            st_d.status = 1'b0;
        end
        if (cmd_i.st_set || evt_i) begin
            st_d.status = 1'b1;
        end
        if (cmd_i.en_set) begin
            st_d.enable = 1'b1;
        end
        if (cmd_i.en_clr) begin
            st_d.enable = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign enable_o = st_q.enable;
    assign irq_o    = st_q.status & st_q.enable;

    // R4: a forced set always lands
    a_r4_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.st_set |=> status_o);

    // R5: a clear without a competing set empties the status
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.st_clr && !cmd_i.st_set && !evt_i) |=> !status_o);

    // R5: detection wins over a clear in the same cycle
    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && cmd_i.st_clr) |=> status_o);

    // R1: pending status is sticky until cleared
    a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !cmd_i.st_clr) |=> status_o);

    // R6: enable clear wins over enable set
    a_r6_en_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.en_clr |=> !enable_o);

    // R6: lone enable set takes effect
    a_r6_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.en_set && !cmd_i.en_clr) |=> enable_o);

    // R6: enable holds without a command
    a_r6_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_i.en_set && !cmd_i.en_clr) |=> $stable(enable_o));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl_i,
    input  logic [NUM_PINS-1:0] det_en_i,
    input  logic [NUM_PINS-1:0] edge_mode_i,
    input  logic                wr_en_i,
    input  logic [PIN_W-1:0]    wr_pin_i,
    input  logic [CMD_W-1:0]    wr_cmd_i,
    output logic [NUM_PINS-1:0] status_o,
    output logic [NUM_PINS-1:0] enable_o,
    output logic [NUM_PINS-1:0] irq_o
);

    irq_cmd_t [NUM_PINS-1:0] pin_cmd;
    logic     [NUM_PINS-1:0] pin_evt;
    logic     [NUM_PINS-1:0] pin_hit;

    irq_cmd_decode #(
        .NUM_PINS (NUM_PINS),
        .PIN_W    (PIN_W)
    ) u_decode (
        .wr_en_i  (wr_en_i),
        .wr_pin_i (wr_pin_i),
        .wr_cmd_i (wr_cmd_i),
        .cmd_o    (pin_cmd)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        irq_edge_detect u_det (
            .clk         (clk),
            .rst_n       (rst_n),
            .lvl_i       (pin_lvl_i[p]),
            .det_en_i    (det_en_i[p]),
            .edge_mode_i (edge_mode_i[p]),
            .evt_o       (pin_evt[p])
        );

        irq_pin_state u_state (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_i    (pin_evt[p]),
            .cmd_i    (pin_cmd[p]),
            .status_o (status_o[p]),
            .enable_o (enable_o[p]),
            .irq_o    (irq_o[p])
        );

        assign pin_hit[p] = |pin_cmd[p];
    end

    // R9: one write reaches at most one pin
    a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_hit));

    // R8: a request never appears on a masked pin
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~enable_o) == '0);

endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;

    localparam int N  = 8;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [N-1:0]  lvl, den, edm;
    logic          wr_en;
    logic [PW-1:0] wr_pin;
    logic [3:0]    wr_cmd;
    logic [N-1:0]  status_o, enable_o, irq_o;

    logic [N-1:0]  m_st, m_en, m_prev;
    int            n_chk  = 0;
    int            n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_irq_bank #(.NUM_PINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_lvl_i(lvl), .det_en_i(den),
        .edge_mode_i(edm), .wr_en_i(wr_en), .wr_pin_i(wr_pin),
        .wr_cmd_i(wr_cmd), .status_o(status_o), .enable_o(enable_o),
        .irq_o(irq_o)
    );

    task automatic chk_vec(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic chk_bit(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Reference: next state of every pin from the present inputs.
    function automatic logic evt_of(int p);
        if (!den[p]) return 1'b0;
        return edm[p] ? (lvl[p] & ~m_prev[p]) : lvl[p];
    endfunction

    task automatic model_step();
        for (int p = 0; p < N; p++) begin
            logic hit;
            hit = wr_en && (int'(wr_pin) == p);
            if (evt_of(p) || (hit && wr_cmd[1]))  m_st[p] = 1'b1;
            else if (hit && wr_cmd[0])            m_st[p] = 1'b0;
            if (hit && wr_cmd[2])                 m_en[p] = 1'b0;
            else if (hit && wr_cmd[3])            m_en[p] = 1'b1;
            m_prev[p] = lvl[p];
        end
    endtask

    // Inputs already driven at a falling edge; advance one clock and compare.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk_vec("R1/R2/R3/R9 status", status_o, m_st);
        chk_vec("R6/R9 enable", enable_o, m_en);
        chk_vec("R8 irq", irq_o, m_st & m_en);
    endtask

    task automatic wr(int pin, logic [3:0] cmd);
        wr_en  = 1'b1;
        wr_pin = PW'(pin);
        wr_cmd = cmd;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; lvl = '0; den = '0; edm = '0;
        wr_en = 1'b0; wr_pin = '0; wr_cmd = '0;
        m_st = '0; m_en = '0; m_prev = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk_vec("R10 status", status_o, '0);
        chk_vec("R10 enable", enable_o, '0);
        chk_vec("R10 irq", irq_o, '0);
        rst_n = 1'b1;

        // R1: rising edge sets, stays after fall
        den[2] = 1; edm[2] = 1; cycle();
        lvl[2] = 1; cycle();
        chk_bit("R1 edge set", status_o[2], 1'b1);
        lvl[2] = 0; cycle();
        chk_bit("R1 sticky", status_o[2], 1'b1);
        // R5: clear
        wr(2, 4'b0001); cycle();
        chk_bit("R5 clear", status_o[2], 1'b0);

        // R4 force with detection off, R8 masked
        wr(5, 4'b0010); cycle();
        chk_bit("R4 force", status_o[5], 1'b1);
        chk_bit("R8 masked", irq_o[5], 1'b0);
        wr(5, 4'b1000); cycle();
        chk_bit("R6 enable set", enable_o[5], 1'b1);
        chk_bit("R8 request", irq_o[5], 1'b1);
        wr(5, 4'b1100); cycle();
        chk_bit("R6 clear wins", enable_o[5], 1'b0);
        // R7 combined mask and acknowledge
        wr(5, 4'b1000); cycle();
        wr(5, 4'b0101); cycle();
        chk_bit("R7 status", status_o[5], 1'b0);
        chk_bit("R7 enable", enable_o[5], 1'b0);

        // R2 level mode: clear ineffective while high
        den[3] = 1; edm[3] = 0; lvl[3] = 1; cycle();
        chk_bit("R2 level set", status_o[3], 1'b1);
        wr(3, 4'b0001); cycle();
        chk_bit("R2 clear while high", status_o[3], 1'b1);
        lvl[3] = 0; cycle();
        wr(3, 4'b0001); cycle();
        chk_bit("R2 clear after drop", status_o[3], 1'b0);

        // R5: event beats clear in same cycle
        den[4] = 1; edm[4] = 1; cycle();
        lvl[4] = 1; wr(4, 4'b0001); cycle();
        chk_bit("R5 event wins", status_o[4], 1'b1);

        // R3 / R11: history tracked while off
        edm[6] = 1; lvl[6] = 1; cycle();
        lvl[6] = 0; cycle();
        lvl[6] = 1; cycle();
        chk_bit("R3 off no set", status_o[6], 1'b0);
        den[6] = 1; cycle();
        chk_bit("R11 no edge on enable", status_o[6], 1'b0);

        // R9: write touches only pin 1
        wr(1, 4'b1010); cycle();
        chk_bit("R9 target", irq_o[1], 1'b1);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            lvl = N'($urandom);
            if (($urandom % 8) == 0) den = N'($urandom);
            if (($urandom % 8) == 0) edm = N'($urandom);
            if (($urandom % 3) == 0) wr(int'($urandom % N), 4'($urandom));
            cycle();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule